// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit integer pipeline and a byte-addressed data memory whose words are 32 bits wide. For each request it adds a 16-bit signed offset to a base register value to form the effective byte address. It decodes a 6-bit memory opcode into direction, access size and signedness. The memory is big-endian: the byte at offset 0 of a word travels on the most significant lane, bits 31:24. A store moves its data onto the byte lanes that match the address and raises the write enable of each lane written. A load picks the addressed byte or halfword out of the returned word and widens it to a full 32-bit register value.

Requests use a valid/ready handshake. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. An aligned load or store is forwarded to memory in the same cycle through `mem_valid`/`mem_ready`. While `mem_ready` is low, `req_ready` stays low and the request must be held stable. A misaligned or unsupported request needs no memory cycle, so it is accepted even when memory stalls. One load may be outstanding. From the cycle after its acceptance until its data returns on `mem_rvalid`, `req_ready` is low and `mem_valid` stays low. The widened load result appears combinationally in the return cycle, together with a one-cycle write-back strobe.

Top module: `lsa_aligner`

## Requirements
- R1: `mem_addr` equals `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32.
- R2: Supported opcodes are 32 signed byte load, 33 signed halfword load, 35 word load, 36 unsigned byte load, 37 unsigned halfword load, 40 byte store, 41 halfword store and 43 word store. Any other opcode is accepted without raising `mem_valid`, `align_err` or a later `ld_wen`.
- R3: A word access whose address bits 1:0 are not 00, or a halfword access with address bit 0 set, is misaligned. It raises `align_err` in its acceptance cycle, keeps `mem_valid` low and `mem_we` at 0000, and produces no `ld_wen`.
- R4: A byte store drives the low data byte on all four lanes of `mem_wdata`. It sets only `mem_we[3 - addr[1:0]]`, where `mem_we[3]` enables bits 31:24.
- R5: A halfword store drives the low 16 data bits on both halves of `mem_wdata`. It sets `mem_we` = 1100 when address bit 1 is 0 and 0011 when it is 1.
- R6: A word store passes `req_wdata` unchanged with `mem_we` = 1111.
- R7: Every load request drives `mem_we` = 0000.
- R8: A byte load returns the byte at offset k, which is `mem_rdata[31-8k:24-8k]`. Opcode 32 sign-extends it and opcode 36 zero-extends it to 32 bits.
- R9: A halfword load returns `mem_rdata[31:16]` for address bit 1 = 0 and `mem_rdata[15:0]` otherwise. Opcode 33 sign-extends it and opcode 37 zero-extends it.
- R10: A word load returns `mem_rdata` unchanged.
- R11: `ld_wen` is high exactly in the cycle that `mem_rvalid` arrives while a load is outstanding, for one cycle, with `ld_data` valid combinationally in that cycle. `mem_rvalid` with no outstanding load is ignored.
- R12: `req_ready` is low while a load is outstanding. With none outstanding, `req_ready` follows `mem_ready` for an aligned supported request and is high for any other request.
- R13: After reset no load is outstanding, `ld_wen` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 6 | Memory opcode |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte offset |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | 32 | Effective byte address |
| mem_we | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rvalid | input | 1 | Load data returned |
| mem_rdata | input | 32 | Returned memory word |
| ld_wen | output | 1 | Register write-back strobe |
| ld_data | output | 32 | Extended load result |
| align_err | output | 1 | Misaligned access flag |

## Verification
The bench attacks lane numbering at both ends of the word. A design with little-endian numbering would enable `mem_we[0]` for offset 0 and return the wrong byte for offsets 0 and 3. It also targets sign extension with bytes and halfwords whose top bit is set. Here, zero-filling a signed load or sign-filling an unsigned one changes the upper 24 or 16 bits. Negative offsets and an address that wraps past 2^32 would expose an offset that is zero-extended or truncated. Misaligned and unsupported requests are each followed by a stray `mem_rvalid`, so that a design which still writes back or leaves a load pending would show `ld_wen`. Stalls on `mem_ready`, and a request presented while a load is outstanding, would show a design that accepts twice or drops the handshake.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_NONE} acc_size_e;

  typedef struct packed {
    logic      known;
    logic      is_load;
    logic      signed_ext;
    acc_size_e size;
  } acc_desc_t;

  localparam logic [5:0] OPC_LDB  = 6'd32;
  localparam logic [5:0] OPC_LDH  = 6'd33;
  localparam logic [5:0] OPC_LDW  = 6'd35;
  localparam logic [5:0] OPC_LDBU = 6'd36;
  localparam logic [5:0] OPC_LDHU = 6'd37;
  localparam logic [5:0] OPC_STB  = 6'd40;
  localparam logic [5:0] OPC_STH  = 6'd41;
  localparam logic [5:0] OPC_STW  = 6'd43;

  function automatic acc_desc_t decode_op(input logic [5:0] op);
    acc_desc_t d;
    d = '{known: 1'b1, is_load: 1'b1, signed_ext: 1'b0, size: SZ_WORD};
    case (op)
      OPC_LDB:  begin d.signed_ext = 1'b1; d.size = SZ_BYTE; end
      OPC_LDH:  begin d.signed_ext = 1'b1; d.size = SZ_HALF; end
      OPC_LDW:  d.size = SZ_WORD;
      OPC_LDBU: d.size = SZ_BYTE;
      OPC_LDHU: d.size = SZ_HALF;
      OPC_STB:  begin d.is_load = 1'b0; d.size = SZ_BYTE; end
      OPC_STH:  begin d.is_load = 1'b0; d.size = SZ_HALF; end
      OPC_STW:  begin d.is_load = 1'b0; d.size = SZ_WORD; end
      default:  begin d.known = 1'b0; d.is_load = 1'b0; d.size = SZ_NONE; end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int OFS_W    = 16,
  parameter int OFS_BITS = 2
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [OFS_W-1:0]    offset,
  input  lsa_pkg::acc_size_e  size,
  output logic [ADDR_W-1:0]   eff_addr,
  output logic                misaligned
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;

  assign ofs_ext  = {{EXT_W{offset[OFS_W-1]}}, offset};
  assign eff_addr = base + ofs_ext;

  always_comb begin
    case (size)
      lsa_pkg::SZ_HALF: misaligned = eff_addr[0];
      lsa_pkg::SZ_WORD: misaligned = |eff_addr[OFS_BITS-1:0];
      default:          misaligned = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes #(
  parameter int DATA_W = 32
) (
  input  lsa_pkg::acc_size_e        size,
  input  logic [$clog2(DATA_W/8)-1:0] ofs,
  input  logic [DATA_W-1:0]         wdata_in,
  output logic [DATA_W/8-1:0]       lane_we,
  output logic [DATA_W-1:0]         wdata_out
);
  localparam int LANES    = DATA_W / 8;
  localparam int OFS_BITS = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFS_BITS-1:0] POS = OFS_BITS'(i);
    logic       en;
    logic [7:0] byte_val;

    always_comb begin
      case (size)
        lsa_pkg::SZ_BYTE: en = (ofs == POS);
        lsa_pkg::SZ_HALF: en = (ofs[OFS_BITS-1:1] == POS[OFS_BITS-1:1]);
        lsa_pkg::SZ_WORD: en = 1'b1;
        default:          en = 1'b0;
      endcase
    end

    always_comb begin
      case (size)
        lsa_pkg::SZ_BYTE: byte_val = wdata_in[7:0];
        lsa_pkg::SZ_HALF: byte_val = POS[0] ? wdata_in[7:0] : wdata_in[15:8];
        default:          byte_val = wdata_in[DATA_W-1-8*i -: 8];
      endcase
    end

    assign lane_we[LANES-1-i]           = en;
    assign wdata_out[DATA_W-1-8*i -: 8] = byte_val;
  end
endmodule

// File: rtl/lsa_load_extend.sv
module lsa_load_extend #(
  parameter int DATA_W = 32
) (
  input  lsa_pkg::acc_size_e          size,
  input  logic                        signed_ext,
  input  logic [$clog2(DATA_W/8)-1:0] ofs,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           result
);
  localparam int OFS_BITS = $clog2(DATA_W / 8);

  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  logic [OFS_BITS-1:0] ofs_h;

  assign ofs_h = {ofs[OFS_BITS-1:1], 1'b0};

  always_comb begin
    sel_b = rdata[DATA_W-1-8*int'(ofs) -: 8];
    sel_h = rdata[DATA_W-1-8*int'(ofs_h) -: 16];
  end

  always_comb begin
    case (size)
      lsa_pkg::SZ_BYTE: result = {{(DATA_W-8){signed_ext & sel_b[7]}}, sel_b};
      lsa_pkg::SZ_HALF: result = {{(DATA_W-16){signed_ext & sel_h[15]}}, sel_h};
      default:          result = rdata;
    endcase
  end
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [5:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_wen,
  output logic [DATA_W-1:0] ld_data,
  output logic              align_err
);
  localparam int LANES    = DATA_W / 8;
  localparam int OFS_BITS = $clog2(LANES);

  lsa_pkg::acc_desc_t  desc;
  logic                misaligned;
  logic [ADDR_W-1:0]   eff_addr;
  logic [LANES-1:0]    lane_we;
  logic [DATA_W-1:0]   lane_wdata;
  logic                pend_q;
  logic [OFS_BITS-1:0] ofs_q;
  lsa_pkg::acc_size_e  size_q;
  logic                sext_q;
  logic                mem_go;
  logic                load_accept;

  assign desc = lsa_pkg::decode_op(req_op);

  lsa_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .OFS_BITS(OFS_BITS)) u_agen (
    .base       (req_base),
    .offset     (req_offset),
    .size       (desc.size),
    .eff_addr   (eff_addr),
    .misaligned (misaligned)
  );

  lsa_store_lanes #(.DATA_W(DATA_W)) u_lanes (
    .size      (desc.size),
    .ofs       (eff_addr[OFS_BITS-1:0]),
    .wdata_in  (req_wdata),
    .lane_we   (lane_we),
    .wdata_out (lane_wdata)
  );

  lsa_load_extend #(.DATA_W(DATA_W)) u_ext (
    .size       (size_q),
    .signed_ext (sext_q),
    .ofs        (ofs_q),
    .rdata      (mem_rdata),
    .result     (ld_data)
  );

  assign mem_go      = desc.known && !misaligned;
  assign req_ready   = !pend_q && (!mem_go || mem_ready);
  assign mem_valid   = req_valid && !pend_q && mem_go;
  assign mem_addr    = eff_addr;
  assign mem_wdata   = lane_wdata;
  assign mem_we      = (mem_valid && !desc.is_load) ? lane_we : '0;
  assign align_err   = req_valid && !pend_q && desc.known && misaligned;
  assign load_accept = mem_valid && mem_ready && desc.is_load;
  assign ld_wen      = pend_q && mem_rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ofs_q  <= '0;
      size_q <= lsa_pkg::SZ_WORD;
      sext_q <= 1'b0;
    end else if (load_accept) begin
      pend_q <= 1'b1;
      ofs_q  <= eff_addr[OFS_BITS-1:0];
      size_q <= desc.size;
      sext_q <= desc.signed_ext;
    end else if (mem_rvalid) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lsa_aligner_chk.sv
module lsa_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [5:0] req_op,
  input logic       mem_valid,
  input logic       mem_ready,
  input logic [3:0] mem_we,
  input logic       mem_rvalid,
  input logic       ld_wen,
  input logic       align_err
);
  logic op_is_load;
  assign op_is_load = (req_op == 6'd32) || (req_op == 6'd33) || (req_op == 6'd35) ||
                      (req_op == 6'd36) || (req_op == 6'd37);

  a_r3_err_blocks_mem: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_valid && mem_we == 4'b0000));

  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_op == 6'd40) |-> ($countones(mem_we) == 1));

  a_r6_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_op == 6'd43) |-> (mem_we == 4'b1111));

  a_r7_load_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    op_is_load |-> (mem_we == 4'b0000));

  a_r11_wen_needs_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wen |-> mem_rvalid);

  a_r11_wen_single: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wen |=> !ld_wen);

  a_r12_block_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && op_is_load) |=> !req_ready);

  a_r12_mem_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (req_valid && !align_err));
endmodule

bind lsa_aligner lsa_aligner_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_rvalid (mem_rvalid),
  .ld_wen     (ld_wen),
  .align_err  (align_err)
);

// File: tb/lsa_aligner_test.sv
`timescale 1ns/1ps
module lsa_aligner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ld_wen;
  logic [31:0] ld_data;
  logic        align_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lsa_aligner uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_wen(ld_wen), .ld_data(ld_data), .align_err(align_err)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [31:0] addr;
    logic [3:0]  we;
    logic [31:0] mwd;
    logic        mv;
    logic        err;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{6'd43, 32'h00001000, 16'h0004, 32'hA1B2C3D4, 32'h0, 32'h00001004, 4'hF, 32'hA1B2C3D4, 1'b1, 1'b0, 32'h0},
    '{6'd40, 32'h00001000, 16'h0003, 32'h000000EE, 32'h0, 32'h00001003, 4'h1, 32'hEEEEEEEE, 1'b1, 1'b0, 32'h0},
    '{6'd40, 32'h00001000, 16'h0001, 32'h12345677, 32'h0, 32'h00001001, 4'h4, 32'h77777777, 1'b1, 1'b0, 32'h0},
    '{6'd41, 32'h00002000, 16'hFFFE, 32'h0000BEEF, 32'h0, 32'h00001FFE, 4'h3, 32'hBEEFBEEF, 1'b1, 1'b0, 32'h0},
    '{6'd41, 32'h00002000, 16'h0000, 32'h0000CAFE, 32'h0, 32'h00002000, 4'hC, 32'hCAFECAFE, 1'b1, 1'b0, 32'h0},
    '{6'd43, 32'hFFFFFFFC, 16'h0008, 32'h55AA55AA, 32'h0, 32'h00000004, 4'hF, 32'h55AA55AA, 1'b1, 1'b0, 32'h0},
    '{6'd43, 32'h00002000, 16'h0002, 32'h11111111, 32'h0, 32'h00002002, 4'h0, 32'h0,        1'b0, 1'b1, 32'h0},
    '{6'd41, 32'h00002001, 16'h0000, 32'h22222222, 32'h0, 32'h00002001, 4'h0, 32'h0,        1'b0, 1'b1, 32'h0},
    '{6'd32, 32'h00003000, 16'h0001, 32'h0, 32'h11F23344, 32'h00003001, 4'h0, 32'h0, 1'b1, 1'b0, 32'hFFFFFFF2},
    '{6'd36, 32'h00003000, 16'h0001, 32'h0, 32'h11F23344, 32'h00003001, 4'h0, 32'h0, 1'b1, 1'b0, 32'h000000F2},
    '{6'd32, 32'h00003000, 16'h0003, 32'h0, 32'h11F23344, 32'h00003003, 4'h0, 32'h0, 1'b1, 1'b0, 32'h00000044},
    '{6'd33, 32'h00003000, 16'h0002, 32'h0, 32'h12348001, 32'h00003002, 4'h0, 32'h0, 1'b1, 1'b0, 32'hFFFF8001},
    '{6'd37, 32'h00003000, 16'h0000, 32'h0, 32'h9ABC5678, 32'h00003000, 4'h0, 32'h0, 1'b1, 1'b0, 32'h00009ABC},
    '{6'd33, 32'h00003000, 16'h0000, 32'h0, 32'h9ABC5678, 32'h00003000, 4'h0, 32'h0, 1'b1, 1'b0, 32'hFFFF9ABC},
    '{6'd35, 32'h00004000, 16'hFFFC, 32'h0, 32'hDEADBEEF, 32'h00003FFC, 4'h0, 32'h0, 1'b1, 1'b0, 32'hDEADBEEF},
    '{6'd35, 32'h00004000, 16'h0001, 32'h0, 32'h0,        32'h00004001, 4'h0, 32'h0, 1'b0, 1'b1, 32'h0},
    '{6'd32, 32'h00003000, 16'h0000, 32'h0, 32'h80FFFFFF, 32'h00003000, 4'h0, 32'h0, 1'b1, 1'b0, 32'hFFFFFF80},
    '{6'd36, 32'h00003000, 16'h0002, 32'h0, 32'h0000A500, 32'h00003002, 4'h0, 32'h0, 1'b1, 1'b0, 32'h000000A5},
    '{6'd00, 32'h00005000, 16'h0000, 32'h0, 32'h0,        32'h00005000, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0},
    '{6'd37, 32'h00003003, 16'h0000, 32'h0, 32'h0,        32'h00003003, 4'h0, 32'h0, 1'b0, 1'b1, 32'h0},
    '{6'd40, 32'h00003003, 16'hFFFF, 32'h000000AB, 32'h0, 32'h00003002, 4'h2, 32'hABABABAB, 1'b1, 1'b0, 32'h0}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_load_op(input logic [5:0] op);
    return op == 6'd32 || op == 6'd33 || op == 6'd35 || op == 6'd36 || op == 6'd37;
  endfunction

  function automatic string lane_tag(input logic [5:0] op);
    case (op)
      6'd40:   return "R4 byte store lanes";
      6'd41:   return "R5 half store lanes";
      6'd43:   return "R6 word store lanes";
      default: return "R7 load write enables";
    endcase
  endfunction

  function automatic string load_tag(input logic [5:0] op);
    case (op)
      6'd32, 6'd36: return "R8 byte load value";
      6'd33, 6'd37: return "R9 half load value";
      default:      return "R10 word load value";
    endcase
  endfunction

  task automatic drive_req(input logic [5:0] op, input logic [31:0] base,
                           input logic [15:0] off, input logic [31:0] wd);
    req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_wdata = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R13: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ld_wen == 1'b0, "R13 ld_wen in reset", 32'(ld_wen), 32'd0);
    check(req_ready == 1'b1, "R13 req_ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'h12345678;
    #1 check(ld_wen == 1'b0, "R13 no pending load after reset", 32'(ld_wen), 32'd0);
    @(negedge clk);
    mem_rvalid = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mem_ready = 1'b1;
      drive_req(VECS[i].op, VECS[i].base, VECS[i].off, VECS[i].wd);
      #1;
      check(mem_valid == VECS[i].mv,
            VECS[i].err ? "R3 misaligned holds mem_valid" : "R2 mem_valid by opcode",
            32'(mem_valid), 32'(VECS[i].mv));
      check(align_err == VECS[i].err, "R3 align_err", 32'(align_err), 32'(VECS[i].err));
      check(req_ready == 1'b1, "R12 req_ready idle", 32'(req_ready), 32'd1);
      check(mem_addr == VECS[i].addr, "R1 effective address", mem_addr, VECS[i].addr);
      check(mem_we == VECS[i].we, VECS[i].mv ? lane_tag(VECS[i].op) : "R3 no write enable",
            32'(mem_we), 32'(VECS[i].we));
      if (VECS[i].mv && !is_load_op(VECS[i].op))
        check(mem_wdata == VECS[i].mwd, lane_tag(VECS[i].op), mem_wdata, VECS[i].mwd);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (VECS[i].mv && is_load_op(VECS[i].op)) begin
        mem_rvalid = 1'b1; mem_rdata = VECS[i].rd;
        #1;
        check(ld_wen == 1'b1, "R11 ld_wen on return", 32'(ld_wen), 32'd1);
        check(ld_data == VECS[i].ld, load_tag(VECS[i].op), ld_data, VECS[i].ld);
      end else if (!VECS[i].mv) begin
        mem_rvalid = 1'b1; mem_rdata = 32'hFFFFFFFF;
        #1;
        check(ld_wen == 1'b0, VECS[i].err ? "R3 no write-back" : "R2 no write-back",
              32'(ld_wen), 32'd0);
      end
      @(posedge clk);
      @(negedge clk);
      mem_rvalid = 1'b0;
    end

    // R12: memory stall holds a store
    @(negedge clk);
    mem_ready = 1'b0;
    drive_req(6'd43, 32'h00006000, 16'h0000, 32'hCAFEF00D);
    #1;
    check(mem_valid == 1'b1, "R12 mem_valid under stall", 32'(mem_valid), 32'd1);
    check(req_ready == 1'b0, "R12 req_ready follows mem_ready", 32'(req_ready), 32'd0);
    @(negedge clk);
    check(mem_valid == 1'b1 && mem_we == 4'hF, "R12 store held under stall", 32'(mem_we), 32'hF);
    // R12 and R3: misaligned accepted while memory stalls
    drive_req(6'd43, 32'h00006001, 16'h0000, 32'h0);
    #1;
    check(req_ready == 1'b1, "R12 misaligned accepted under stall", 32'(req_ready), 32'd1);
    check(align_err == 1'b1, "R3 misaligned under stall", 32'(align_err), 32'd1);
    @(negedge clk);
    mem_ready = 1'b1;
    req_valid = 1'b0;

    // R12: request blocked while a load is outstanding
    @(negedge clk);
    drive_req(6'd35, 32'h00007000, 16'h0000, 32'h0);
    @(posedge clk);
    @(negedge clk);
    drive_req(6'd43, 32'h00007004, 16'h0000, 32'h5A5A5A5A);
    #1;
    check(req_ready == 1'b0, "R12 req_ready low while pending", 32'(req_ready), 32'd0);
    check(mem_valid == 1'b0, "R12 mem_valid low while pending", 32'(mem_valid), 32'd0);
    @(negedge clk);
    check(ld_wen == 1'b0, "R11 no write-back before return", 32'(ld_wen), 32'd0);
    mem_rvalid = 1'b1; mem_rdata = 32'h0BADF00D;
    #1;
    check(ld_wen == 1'b1 && ld_data == 32'h0BADF00D, "R11 return while blocked", ld_data, 32'h0BADF00D);
    check(req_ready == 1'b0, "R12 still blocked in return cycle", 32'(req_ready), 32'd0);
    @(negedge clk);
    mem_rvalid = 1'b0;
    #1;
    check(req_ready == 1'b1 && mem_valid == 1'b1, "R12 released after return", 32'(mem_valid), 32'd1);
    check(ld_wen == 1'b0, "R11 single strobe", 32'(ld_wen), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule